// File: doc/BRIEF.md
# Interrupt Capture and Global Indirect Access

This block sits between a multi-channel serial controller's interrupt bid arbiter and its host register bus. It owns one current-interrupt register. That register latches the 8-bit bid of the source that is winning arbitration, either when the host acknowledges an interrupt or when the host writes an update command. A single read of the register gives the host the channel, the interrupt type and the byte count together.

The block also provides a few virtual registers derived from the captured value. Two of them return the byte count and the channel number, each right-justified. The third is a global data address that has no storage of its own. A read at this address pops the receive FIFO of the interrupting channel. A write at this address pushes into the transmit FIFO of the interrupting channel. The host can therefore service an interrupt without first working out which channel raised it. The bid arbiter and the FIFO storage are outside this block.

Top module: `int_capture_global`

## Requirements
- R1: After reset the captured register is zero, every read returns zero, and no FIFO pop or push strobe is active.
- R2: On the first clock at which `iackN` is sampled low after being high, the captured register takes the value on `bidValue`. While `iackN` stays low it does not capture again.
- R3: A write to offset 4 (update command) captures `bidValue` at that clock edge. The write data is ignored.
- R4: Without an acknowledge edge or an update command, the captured register holds its value. Writes to offsets 0, 1 and 2 do not change it.
- R5: A read at offset 0 returns the whole captured byte. In that byte, bits [1:0] are the channel, bits [4:2] are the type code and bits [7:5] are the count.
- R6: A read at offset 1 returns captured bits [7:5] zero-extended. A read at offset 2 returns captured bits [1:0] zero-extended.
- R7: When type bits [3:2] are 2'b11 (receiver, with or without error), a read at offset 3 asserts `rxPop` only for the captured channel, during the read cycle. It returns that channel's `rxData` byte.
- R8: When type bits [3:2] are 2'b10 (transmitter), a write at offset 3 asserts `txPush` only for the captured channel, with `txData` equal to the write data.
- R9: A read at offset 3 with a non-receiver type returns zero and pops nothing. A write at offset 3 with a non-transmitter type pushes nothing.
- R10: When a capture and a global FIFO access fall in the same cycle, the access is steered by the value held before that clock edge. The new value applies from the next cycle on.
- R11: Reads at offset 4 and at the unmapped offsets 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iackN | input | 1 | Active-low interrupt acknowledge |
| bidValue | input | 8 | Winning bid from the arbiter |
| regSel | input | 3 | Register offset |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid while regRd is high |
| rxData | input | 32 | Head byte of each receive FIFO, channel 0 in the low byte |
| rxPop | output | 4 | One-hot receive FIFO pop |
| txPush | output | 4 | One-hot transmit FIFO push |
| txData | output | 8 | Data for the transmit FIFO |

## Verification
Two functions can land in the same cycle: capturing a new interrupt identity, and a global FIFO access that depends on that identity. The bench holds a receiver identity for one channel. It then drops `iackN` in the same cycle as a global data read, with a different receiver channel on the bid input. The test passes only if the pop and the returned byte belong to the old channel, and a read at offset 0 in the next cycle shows the new bid.

// File: rtl/icg_pkg.sv
package icg_pkg;
  localparam logic [2:0] OffWhole  = 3'd0;
  localparam logic [2:0] OffCount  = 3'd1;
  localparam logic [2:0] OffChan   = 3'd2;
  localparam logic [2:0] OffData   = 3'd3;
  localparam logic [2:0] OffUpdate = 3'd4;
  localparam int TypeW = 3;

  typedef struct packed {
    logic capture;
    logic rdWhole;
    logic rdCount;
    logic rdChan;
    logic rdFifo;
    logic wrFifo;
  } strobe_t;

  function automatic logic typeIsRx(input logic [TypeW-1:0] t);
    return t[1:0] == 2'b11;
  endfunction

  function automatic logic typeIsTx(input logic [TypeW-1:0] t);
    return t[1:0] == 2'b10;
  endfunction
endpackage

// File: rtl/icg_ctrl.sv
module icg_ctrl
  import icg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       iackN,
  input  logic [2:0] regSel,
  input  logic       regRd,
  input  logic       regWr,
  output strobe_t    strb
);
  logic iackPrev;
  logic ackEdge;

  always_ff @(posedge clk) begin
    if (!rstN) iackPrev <= 1'b1;
    else       iackPrev <= iackN;
  end

  assign ackEdge = iackPrev & ~iackN;

  always_comb begin
    strb         = '0;
    strb.capture = ackEdge | (regWr && regSel == OffUpdate);
    strb.rdWhole = regRd && regSel == OffWhole;
    strb.rdCount = regRd && regSel == OffCount;
    strb.rdChan  = regRd && regSel == OffChan;
    strb.rdFifo  = regRd && regSel == OffData;
    strb.wrFifo  = regWr && regSel == OffData;
  end
endmodule

// File: rtl/icg_datapath.sv
module icg_datapath
  import icg_pkg::*;
#(
  parameter int NumChan = 4,
  parameter int DataW   = 8,
  parameter int CountW  = 3,
  parameter int ChanW   = 2,
  localparam int BidW   = CountW + TypeW + ChanW
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [BidW-1:0]          bidValue,
  input  logic [DataW-1:0]         regWdata,
  input  logic [NumChan*DataW-1:0] rxData,
  output logic [DataW-1:0]         regRdata,
  output logic [NumChan-1:0]       rxPop,
  output logic [NumChan-1:0]       txPush,
  output logic [DataW-1:0]         txData,
  output logic [BidW-1:0]          capReg
);
  logic [ChanW-1:0]  chanField;
  logic [TypeW-1:0]  typeField;
  logic [CountW-1:0] countField;
  logic [DataW-1:0]  rxSel;
  logic              rxOk;
  logic              txOk;

  always_ff @(posedge clk) begin
    if (!rstN)            capReg <= '0;
    else if (strb.capture) capReg <= bidValue;
  end

  assign chanField  = capReg[ChanW-1:0];
  assign typeField  = capReg[ChanW +: TypeW];
  assign countField = capReg[BidW-1 -: CountW];
  assign rxOk       = typeIsRx(typeField);
  assign txOk       = typeIsTx(typeField);
  assign txData     = regWdata;

  for (genvar c = 0; c < NumChan; c++) begin : g_steer
    assign rxPop[c]  = strb.rdFifo & rxOk & (chanField == ChanW'(c));
    assign txPush[c] = strb.wrFifo & txOk & (chanField == ChanW'(c));
  end

  always_comb begin
    rxSel = '0;
    for (int i = 0; i < NumChan; i++) begin
      if (chanField == ChanW'(i)) rxSel = rxData[i*DataW +: DataW];
    end
  end

  always_comb begin
    regRdata = '0;
    if (strb.rdWhole)        regRdata = DataW'(capReg);
    else if (strb.rdCount)   regRdata = DataW'(countField);
    else if (strb.rdChan)    regRdata = DataW'(chanField);
    else if (strb.rdFifo && rxOk) regRdata = rxSel;
  end
endmodule

// File: rtl/int_capture_global.sv
module int_capture_global
  import icg_pkg::*;
#(
  parameter int NumChan = 4,
  parameter int DataW   = 8,
  parameter int CountW  = 3,
  localparam int ChanW  = $clog2(NumChan),
  localparam int BidW   = CountW + TypeW + ChanW
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     iackN,
  input  logic [BidW-1:0]          bidValue,
  input  logic [2:0]               regSel,
  input  logic                     regRd,
  input  logic                     regWr,
  input  logic [DataW-1:0]         regWdata,
  output logic [DataW-1:0]         regRdata,
  input  logic [NumChan*DataW-1:0] rxData,
  output logic [NumChan-1:0]       rxPop,
  output logic [NumChan-1:0]       txPush,
  output logic [DataW-1:0]         txData
);
  strobe_t         strb;
  logic [BidW-1:0] capReg;

  icg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .iackN(iackN), .regSel(regSel),
    .regRd(regRd), .regWr(regWr), .strb(strb)
  );

  icg_datapath #(
    .NumChan(NumChan), .DataW(DataW), .CountW(CountW), .ChanW(ChanW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bidValue(bidValue),
    .regWdata(regWdata), .rxData(rxData), .regRdata(regRdata),
    .rxPop(rxPop), .txPush(txPush), .txData(txData), .capReg(capReg)
  );
endmodule

// File: rtl/icg_checker.sv
module icg_checker #(
  parameter int NumChan = 4,
  parameter int BidW    = 8,
  parameter int ChanW   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               iackN,
  input logic [BidW-1:0]    bidValue,
  input logic [2:0]         regSel,
  input logic               regRd,
  input logic               regWr,
  input logic [NumChan-1:0] rxPop,
  input logic [NumChan-1:0] txPush,
  input logic [BidW-1:0]    capReg
);
  AST_ACK_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(iackN) |=> capReg == $past(bidValue)); // R2
  AST_UPDATE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 3'd4) |=> capReg == $past(bidValue)); // R3
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (!$fell(iackN) && !(regWr && regSel == 3'd4)) |=> $stable(capReg)); // R4
  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxPop)); // R7
  AST_POP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (|rxPop) |-> (regRd && regSel == 3'd3 && capReg[ChanW+1:ChanW] == 2'b11
                  && rxPop[capReg[ChanW-1:0]])); // R9
  AST_PUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txPush)); // R8
  AST_PUSH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (|txPush) |-> (regWr && regSel == 3'd3 && capReg[ChanW+1:ChanW] == 2'b10
                   && txPush[capReg[ChanW-1:0]])); // R9
endmodule

bind int_capture_global icg_checker #(
  .NumChan(NumChan), .BidW(BidW), .ChanW(ChanW)
) u_chk (
  .clk(clk), .rstN(rstN), .iackN(iackN), .bidValue(bidValue),
  .regSel(regSel), .regRd(regRd), .regWr(regWr),
  .rxPop(rxPop), .txPush(txPush), .capReg(capReg)
);

// File: tb/int_capture_global_test.sv
`timescale 1ns/1ps
module int_capture_global_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iackN = 1'b1;
  logic [7:0]  bidValue = '0;
  logic [2:0]  regSel = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic [31:0] rxData = 32'hA3A2A1A0;
  logic [3:0]  rxPop;
  logic [3:0]  txPush;
  logic [7:0]  txData;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [7:0] rdVal;
  logic [3:0] popVal;
  logic [3:0] pushVal;
  logic [7:0] txVal;

  always #2.5 clk = ~clk;

  int_capture_global uut (
    .clk(clk), .rstN(rstN), .iackN(iackN), .bidValue(bidValue),
    .regSel(regSel), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .rxData(rxData), .rxPop(rxPop),
    .txPush(txPush), .txData(txData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [2:0] sel);
    @(negedge clk);
    regRd = 1'b1; regSel = sel;
    #1;
    rdVal = regRdata; popVal = rxPop; pushVal = txPush;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic doWrite(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWdata = d;
    #1;
    popVal = rxPop; pushVal = txPush; txVal = txData;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic doAck(input logic [7:0] b);
    @(negedge clk);
    bidValue = b; iackN = 1'b0;
    @(negedge clk);
    iackN = 1'b1;
  endtask

  task automatic doUpdate(input logic [7:0] b);
    @(negedge clk);
    bidValue = b;
    doWrite(3'd4, 8'hFF);
  endtask

  task automatic testReset();
    doRead(3'd0);
    check("R1 reset captured", rdVal, 8'h00);
    check("R1 reset strobes", {popVal, pushVal}, 8'h00);
  endtask

  task automatic testAckFields();
    doAck(8'hAD);                       // count 5, rx no error, channel 1
    doRead(3'd0); check("R2 R5 whole", rdVal, 8'hAD);
    doRead(3'd1); check("R6 count", rdVal, 8'h05);
    doRead(3'd2); check("R6 channel", rdVal, 8'h01);
  endtask

  task automatic testAckHeldLow();
    @(negedge clk); bidValue = 8'h2E; iackN = 1'b0;
    @(negedge clk); bidValue = 8'hC3;
    repeat (3) @(negedge clk);
    iackN = 1'b1;
    doRead(3'd0); check("R2 single capture", rdVal, 8'h2E);
  endtask

  task automatic testUpdate();
    doUpdate(8'h4E);                    // count 2, rx, channel 2
    doRead(3'd0); check("R3 update", rdVal, 8'h4E);
    @(negedge clk); bidValue = 8'h11;
    doWrite(3'd0, 8'h77); doWrite(3'd1, 8'h77); doWrite(3'd2, 8'h77);
    doRead(3'd0); check("R4 hold", rdVal, 8'h4E);
  endtask

  task automatic testRxRead();
    doRead(3'd3);
    check("R7 pop ch2", popVal, 4'b0100);
    check("R7 data ch2", rdVal, 8'hA2);
    doUpdate(8'h3C);                    // rx with error, channel 0
    doRead(3'd3);
    check("R7 pop ch0 err", {popVal, rdVal}, {4'b0001, 8'hA0});
    doWrite(3'd3, 8'h99);
    check("R9 write with rx type", pushVal, 4'b0000);
  endtask

  task automatic testTxWrite();
    doUpdate(8'h6B);                    // tx, channel 3
    doWrite(3'd3, 8'h5C);
    check("R8 push ch3", pushVal, 4'b1000);
    check("R8 txData", txVal, 8'h5C);
    doRead(3'd3);
    check("R9 read with tx type", {popVal, rdVal}, 12'h000);
    doUpdate(8'h91);                    // break type, channel 1
    doRead(3'd3);
    check("R9 read with break type", {popVal, rdVal}, 12'h000);
  endtask

  task automatic testUnmapped();
    for (int s = 4; s < 8; s++) begin
      doRead(3'(s));
      check("R11 unmapped read", rdVal, 8'h00);
    end
  endtask

  task automatic testSameCycle();
    doUpdate(8'hAD);                    // rx channel 1
    @(negedge clk);
    regRd = 1'b1; regSel = 3'd3; iackN = 1'b0; bidValue = 8'h0E; // rx channel 2
    #1;
    check("R10 pop uses old channel", rxPop, 4'b0010);
    check("R10 data uses old channel", regRdata, 8'hA1);
    @(negedge clk);
    regRd = 1'b0; iackN = 1'b1;
    doRead(3'd0); check("R10 new value after edge", rdVal, 8'h0E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAckFields();
    testAckHeldLow();
    testUpdate();
    testRxRead();
    testTxWrite();
    testUnmapped();
    testSameCycle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule